// File: doc/BRIEF.md
# Grouped Event Flag Combiner

The block captures single-cycle event pulses from a space of 128 sources into sticky flag bits. The flags are held as four groups of 32; event number `n` lives in group `n / 32` at bit `n mod 32`. Each flag stays set until software clears it. Software can also set flags as though their events had fired.

Two independent mask planes act on the same flags. The interrupt plane reduces each group's unmasked flags to one interrupt line per group. The exception plane reduces the unmasked flags of all groups to a single exception line. The per-group interrupt lines re-enter the flag array as events 0 to 3, so a combined group can itself be collected by another group.

Software reaches the block through a simple word-addressed port with separate read and write strobes. A read is answered by a small two-state responder. State `RD_IDLE` moves to `RD_RESP` on a read strobe. `RD_RESP` stays in `RD_RESP` on a back-to-back strobe and otherwise returns to `RD_IDLE`. The read data and its valid flag appear while the responder is in `RD_RESP`.

Top module: `event_flag_combiner`

## Requirements
- R1: After reset all flags are 0, both mask planes are all ones, `irq_out` is 0 and `exc_out` is 0.
- R2: A high cycle on `evt_in[n]` (n from 4 to 127) sets flag bit `n mod 32` of group `n / 32`. The bit stays set until it is cleared.
- R3: A write to byte address `0x20 + 4*g` sets the group-g flags where the data bits are 1. Data bits that are 0 leave flags unchanged.
- R4: A write to byte address `0x40 + 4*g` clears the group-g flags where the data bits are 1. Data bits that are 0 leave flags unchanged.
- R5: When an event and a software clear target the same flag in the same cycle, the flag ends up set.
- R6: The interrupt mask of group g is written and read at `0x80 + 4*g`, and the exception mask at `0xC0 + 4*g`. A mask bit of 1 blocks its event. The reads at `0xA0 + 4*g` and `0xE0 + 4*g` return the flags AND NOT the interrupt mask or exception mask respectively.
- R7: `irq_out[g]` is high exactly when group g has at least one flag that its interrupt mask lets through.
- R8: `exc_out` is high exactly when any flag in any group is let through by its exception mask.
- R9: Flag bit g of group 0 (events 0 to 3) is set by `irq_out[g]`. There is no external input for these four events.
- R10: A write to byte address `0x1C0` sets the single flag whose event number is `wdata[6:0]`.
- R11: The following accesses read 0 and their writes change nothing: word slots 4 to 7 of each bank, the bank at `0x60`, the set and clear banks on read, addresses at or above `0x100` other than `0x1C0`, and any address with nonzero `addr[1:0]`.
- R12: A read strobe in cycle t gives `rvalid` high and the addressed word on `rdata` in cycle t+1. `rvalid` is low in any cycle that does not follow a read strobe. Raw flags of group g read at `0x00 + 4*g`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 124 ([127:4]) | Event pulses for events 4 to 127 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 9 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read response valid |
| irq_out | output | 4 | Combined interrupt line per group |
| exc_out | output | 1 | Combined exception line |

## Verification
The flags are driven in several ways:
- isolated hardware pulses in different groups, which tell the group/bit split apart from a flat index;
- set and clear words containing mixed ones and zeros, which separate per-bit action from whole-word action;
- an event pulse landing in the same cycle as a clear of its own bit, which exposes the set-versus-clear priority.

Masks are opened one bit at a time in one plane only. This shows that the two planes are independent and that the per-group interrupt feeds back into group 0. Writes and reads at reserved slots, misaligned addresses and the high region are checked for side effects by reading the implemented flags back.

// File: rtl/efc_pkg.sv
package efc_pkg;

    // Register bank selector, taken from byte address bits [7:5]
    typedef enum logic [2:0] {
        BK_RAW   = 3'd0,
        BK_SET   = 3'd1,
        BK_CLR   = 3'd2,
        BK_RSVD  = 3'd3,
        BK_IMASK = 3'd4,
        BK_IMSKD = 3'd5,
        BK_XMASK = 3'd6,
        BK_XMSKD = 3'd7
    } bank_e;

    // Read responder states
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    // Byte address of the single-event trigger register
    localparam int unsigned TRIG_OFFSET = 32'h1C0;

endpackage

// File: rtl/efc_group.sv
module efc_group #(
    parameter int GW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] evt,
    input  logic [GW-1:0] sw_set,
    input  logic [GW-1:0] sw_clr,
    input  logic          imask_we,
    input  logic          xmask_we,
    input  logic [GW-1:0] mask_wdata,
    output logic [GW-1:0] flag_q,
    output logic [GW-1:0] imask_q,
    output logic [GW-1:0] xmask_q,
    output logic          irq_o,
    output logic          exc_o
);

    logic [GW-1:0] flag_d;

    // set sources are OR'ed after the clear so a colliding event survives
    always_comb begin
        flag_d = (flag_q & ~sw_clr) | sw_set | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask_q <= '1;
            xmask_q <= '1;
        end else begin
            if (imask_we) imask_q <= mask_wdata;
            if (xmask_we) xmask_q <= mask_wdata;
        end
    end

    assign irq_o = |(flag_q & ~imask_q);
    assign exc_o = |(flag_q & ~xmask_q);

endmodule

// File: rtl/efc_regif.sv
module efc_regif
    import efc_pkg::*;
#(
    parameter int NG = 4,
    parameter int GW = 32,
    parameter int AW = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [AW-1:0]          addr,
    input  logic [GW-1:0]          wdata,
    input  logic [NG-1:0][GW-1:0]  flags,
    input  logic [NG-1:0][GW-1:0]  imask,
    input  logic [NG-1:0][GW-1:0]  xmask,
    output logic [NG-1:0][GW-1:0]  sw_set,
    output logic [NG-1:0][GW-1:0]  sw_clr,
    output logic [NG-1:0]          imask_we,
    output logic [NG-1:0]          xmask_we,
    output logic [NG*GW-1:0]       trig_evt,
    output logic [GW-1:0]          rdata,
    output logic                   rvalid
);

    localparam int NE = NG * GW;
    localparam int EW = $clog2(NE);

    bank_e       bank;
    logic [2:0]  word;
    logic        low_ok;
    logic        trig_hit;
    logic [GW-1:0] rd_mux;
    rd_state_e   state_q;
    rd_state_e   state_d;

    assign bank     = bank_e'(addr[7:5]);
    assign word     = addr[4:2];
    assign low_ok   = (addr[AW-1:8] == '0) && (addr[1:0] == 2'b00);
    assign trig_hit = wr_en && (addr == AW'(TRIG_OFFSET));

    assign trig_evt = trig_hit ? ({{(NE-1){1'b0}}, 1'b1} << wdata[EW-1:0]) : '0;

    // per-group write decode
    for (genvar g = 0; g < NG; g++) begin : g_wr
        logic hit;
        assign hit         = wr_en && low_ok && (word == 3'(g));
        assign sw_set[g]   = (hit && bank == BK_SET) ? wdata : '0;
        assign sw_clr[g]   = (hit && bank == BK_CLR) ? wdata : '0;
        assign imask_we[g] = hit && (bank == BK_IMASK);
        assign xmask_we[g] = hit && (bank == BK_XMASK);
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < NG; g++) begin
            if (low_ok && word == 3'(g)) begin
                unique case (bank)
                    BK_RAW:   rd_mux = flags[g];
                    BK_IMASK: rd_mux = imask[g];
                    BK_IMSKD: rd_mux = flags[g] & ~imask[g];
                    BK_XMASK: rd_mux = xmask[g];
                    BK_XMSKD: rd_mux = flags[g] & ~xmask[g];
                    BK_SET, BK_CLR, BK_RSVD: rd_mux = '0;
                endcase
            end
        end
    end

    // responder next state
    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    assign rvalid = (state_q == RD_RESP);

endmodule

// File: rtl/event_flag_combiner.sv
module event_flag_combiner #(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 32,
    parameter int ADDR_W     = 9
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:NUM_GROUPS] evt_in,
    input  logic                                wr_en,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [GROUP_W-1:0]                  wdata,
    output logic [GROUP_W-1:0]                  rdata,
    output logic                                rvalid,
    output logic [NUM_GROUPS-1:0]               irq_out,
    output logic                                exc_out
);

    localparam int NE = NUM_GROUPS * GROUP_W;

    logic [NUM_GROUPS-1:0][GROUP_W-1:0] flags;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] imask;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] xmask;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] sw_set;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] sw_clr;
    logic [NUM_GROUPS-1:0]              imask_we;
    logic [NUM_GROUPS-1:0]              xmask_we;
    logic [NE-1:0]                      trig_evt;
    logic [NE-1:0]                      evt_all;
    logic [NUM_GROUPS-1:0]              irq_w;
    logic [NUM_GROUPS-1:0]              exc_w;
    logic [NE-1:0]                      flag_all;
    logic [NE-1:0]                      imask_all;
    logic [NE-1:0]                      xmask_all;

    // combined interrupts re-enter as the lowest events
    assign evt_all = {evt_in, irq_w} | trig_evt;

    efc_regif #(
        .NG (NUM_GROUPS),
        .GW (GROUP_W),
        .AW (ADDR_W)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .flags    (flags),
        .imask    (imask),
        .xmask    (xmask),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr),
        .imask_we (imask_we),
        .xmask_we (xmask_we),
        .trig_evt (trig_evt),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        efc_group #(
            .GW (GROUP_W)
        ) u_group (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (evt_all[g*GROUP_W +: GROUP_W]),
            .sw_set     (sw_set[g]),
            .sw_clr     (sw_clr[g]),
            .imask_we   (imask_we[g]),
            .xmask_we   (xmask_we[g]),
            .mask_wdata (wdata),
            .flag_q     (flags[g]),
            .imask_q    (imask[g]),
            .xmask_q    (xmask[g]),
            .irq_o      (irq_w[g]),
            .exc_o      (exc_w[g])
        );
        assign flag_all[g*GROUP_W +: GROUP_W]  = flags[g];
        assign imask_all[g*GROUP_W +: GROUP_W] = imask[g];
        assign xmask_all[g*GROUP_W +: GROUP_W] = xmask[g];
    end

    assign irq_out = irq_w;
    assign exc_out = |exc_w;

endmodule

// File: rtl/efc_chk.sv
module efc_chk #(
    parameter int NG = 4,
    parameter int GW = 32,
    parameter int AW = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [AW-1:0]        addr,
    input logic [NG*GW-1:NG]    evt_in,
    input logic                 rvalid,
    input logic [NG-1:0]        irq_out,
    input logic                 exc_out,
    input logic [NG*GW-1:0]     flag_all,
    input logic [NG*GW-1:0]     imask_all,
    input logic [NG*GW-1:0]     xmask_all
);

    localparam int NE = NG * GW;

    logic          clr_hit;
    logic [NE-1:0] hw_req;

    assign clr_hit = wr_en && (addr[AW-1:8] == '0) && (addr[7:5] == 3'd2)
                   && (addr[1:0] == 2'b00) && (32'(addr[4:2]) < NG);
    assign hw_req  = {evt_in, {NG{1'b0}}};

    // R12: a read strobe is answered in the next cycle
    p_rd_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R12: no response without a preceding strobe
    p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R2: without a clear write no flag drops
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((flag_all & $past(flag_all)) == $past(flag_all)));

    // R2, R5: a hardware event always lands, clear or not
    p_hw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_req) |=> ((flag_all & $past(hw_req)) == $past(hw_req)));

    // R9: combined interrupts are collected as events 0..NG-1
    p_feedback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |=> ((flag_all[NG-1:0] & $past(irq_out)) == $past(irq_out)));

    // R6: a fully closed interrupt plane silences every group line
    p_irq_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&imask_all) |-> (irq_out == '0));

    // R8: a fully closed exception plane silences the exception line
    p_exc_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&xmask_all) |-> !exc_out);

endmodule

bind event_flag_combiner efc_chk #(
    .NG (NUM_GROUPS),
    .GW (GROUP_W),
    .AW (ADDR_W)
) u_efc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .evt_in    (evt_in),
    .rvalid    (rvalid),
    .irq_out   (irq_out),
    .exc_out   (exc_out),
    .flag_all  (flag_all),
    .imask_all (imask_all),
    .xmask_all (xmask_all)
);

// File: tb/test_event_flag_combiner.sv
module test_event_flag_combiner;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 4;
    localparam int GW = 32;
    localparam int AW = 9;
    localparam int NE = NG * GW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NE-1:NG]  evt_in = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [GW-1:0]   wdata = '0;
    logic [GW-1:0]   rdata;
    logic            rvalid;
    logic [NG-1:0]   irq_out;
    logic            exc_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    event_flag_combiner #(.NUM_GROUPS(NG), .GROUP_W(GW), .ADDR_W(AW)) i_event_flag_combiner (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .irq_out(irq_out), .exc_out(exc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [GW-1:0] m_flag [NG];
    logic [GW-1:0] m_im   [NG];
    logic [GW-1:0] m_xm   [NG];
    logic [GW-1:0] exp_rd = '0;
    logic          exp_rv = 1'b0;

    function automatic logic [NG-1:0] m_irq();
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) r[g] = |(m_flag[g] & ~m_im[g]);
        return r;
    endfunction

    function automatic logic m_exc();
        logic r = 1'b0;
        for (int g = 0; g < NG; g++) r = r | (|(m_flag[g] & ~m_xm[g]));
        return r;
    endfunction

    function automatic logic [GW-1:0] m_read(logic [AW-1:0] a);
        int w = int'(a[4:2]);
        if (a[8] || a[1:0] != 2'b00 || w >= NG) return '0;
        case (a[7:5])
            3'd0: return m_flag[w];
            3'd4: return m_im[w];
            3'd5: return m_flag[w] & ~m_im[w];
            3'd6: return m_xm[w];
            3'd7: return m_flag[w] & ~m_xm[w];
            default: return '0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_flag[g] = '0; m_im[g] = '1; m_xm[g] = '1;
            end
            exp_rv = 1'b0;
        end else begin
            logic [NE-1:0] ev;
            logic [GW-1:0] setv, clrv;
            bit low;
            ev = {evt_in, m_irq()};
            exp_rv = rd_en;
            if (rd_en) exp_rd = m_read(addr);
            low = (addr[8] == 1'b0) && (addr[1:0] == 2'b00);
            for (int g = 0; g < NG; g++) begin
                setv = ev[g*GW +: GW];
                clrv = '0;
                if (wr_en && low && int'(addr[4:2]) == g) begin
                    case (addr[7:5])
                        3'd1: setv = setv | wdata;
                        3'd2: clrv = wdata;
                        3'd4: m_im[g] = wdata;
                        3'd6: m_xm[g] = wdata;
                        default: ;
                    endcase
                end
                if (wr_en && addr == 9'h1C0 && int'(wdata[6:5]) == g)
                    setv[wdata[4:0]] = 1'b1;
                m_flag[g] = (m_flag[g] & ~clrv) | setv;
            end
        end
    end

    task automatic check(string tag, logic [GW-1:0] act, logic [GW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference (R7, R8, R9, R12)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7/R9 irq_out", GW'(irq_out), GW'(m_irq()));
            check("R8 exc_out", GW'(exc_out), GW'(m_exc()));
            check("R12 rvalid", GW'(rvalid), GW'(exp_rv));
            if (exp_rv) check("R12 rdata", rdata, exp_rd);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_write(logic [AW-1:0] a, logic [GW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [AW-1:0] a, output logic [GW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(int idx);
        @(negedge clk);
        evt_in[idx] = 1'b1;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic read_expect(string tag, logic [AW-1:0] a, logic [GW-1:0] e);
        logic [GW-1:0] d;
        do_read(a, d);
        check(tag, d, e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq_out in reset", GW'(irq_out), '0);
        check("R1 exc_out in reset", GW'(exc_out), '0);
        rst_n = 1'b1;

        // R1: reset values
        read_expect("R1 raw flags g0", 9'h000, 32'h0);
        read_expect("R1 int mask g0", 9'h080, 32'hFFFF_FFFF);
        read_expect("R1 exc mask g1", 9'h0C4, 32'hFFFF_FFFF);

        // R2: hardware pulses in different groups
        pulse(37);
        pulse(100);
        repeat (3) @(negedge clk);
        read_expect("R2 group1 bit5", 9'h004, 32'h0000_0020);
        read_expect("R2 group3 bit4", 9'h00C, 32'h0000_0010);
        read_expect("R9 group0 idle with masks closed", 9'h000, 32'h0);

        // R3: write-one-to-set
        do_write(9'h028, 32'h0000_0F00);
        read_expect("R3 set group2", 9'h008, 32'h0000_0F00);
        do_write(9'h028, 32'h0);
        read_expect("R3 zero set no effect", 9'h008, 32'h0000_0F00);

        // R4: write-one-to-clear
        do_write(9'h048, 32'h0000_0300);
        read_expect("R4 clear group2", 9'h008, 32'h0000_0C00);

        // R6, R7, R9: open interrupt mask for event 37
        do_write(9'h084, ~32'h0000_0020);
        check("R7 irq_out group1", GW'(irq_out), 32'h2);
        read_expect("R6 masked irq g1", 9'h0A4, 32'h0000_0020);
        read_expect("R9 feedback into group0", 9'h000, 32'h0000_0002);

        // R6, R8: open exception mask for event 100
        do_write(9'h0CC, ~32'h0000_0010);
        check("R8 exc_out", GW'(exc_out), 32'h1);
        read_expect("R6 masked exc g3", 9'h0EC, 32'h0000_0010);
        read_expect("R6 masked exc g1 closed", 9'h0E4, 32'h0);

        // R4 then R5: clear, then collide event with clear
        do_write(9'h044, 32'h0000_0020);
        check("R7 irq_out falls", GW'(irq_out), 32'h0);
        @(negedge clk);
        evt_in[37] = 1'b1; wr_en = 1'b1; addr = 9'h044; wdata = 32'h0000_0020;
        @(negedge clk);
        evt_in = '0; wr_en = 1'b0;
        read_expect("R5 set wins over clear", 9'h004, 32'h0000_0020);

        // R10: trigger register, event 70 = group2 bit6
        do_write(9'h1C0, 32'd70);
        read_expect("R10 trigger event 70", 9'h008, 32'h0000_0C40);

        // R11: unimplemented slots and addresses
        do_write(9'h034, 32'hFFFF_FFFF);
        do_write(9'h02A, 32'hFFFF_FFFF);
        do_write(9'h128, 32'hFFFF_FFFF);
        do_write(9'h060, 32'hFFFF_FFFF);
        read_expect("R11 writes ignored g2", 9'h008, 32'h0000_0C40);
        read_expect("R11 writes ignored g1", 9'h004, 32'h0000_0020);
        read_expect("R11 slot 5 reads 0", 9'h014, 32'h0);
        read_expect("R11 reserved bank", 9'h060, 32'h0);
        read_expect("R11 set bank reads 0", 9'h024, 32'h0);
        read_expect("R11 misaligned", 9'h005, 32'h0);
        read_expect("R11 trigger reads 0", 9'h1C0, 32'h0);

        // back-to-back reads (R12)
        @(negedge clk);
        rd_en = 1'b1; addr = 9'h004;
        @(negedge clk);
        check("R12 first of pair", rdata, 32'h0000_0020);
        addr = 9'h008;
        @(negedge clk);
        rd_en = 1'b0;
        check("R12 second of pair", rdata, 32'h0000_0C40);

        // close everything and clear all
        for (int g = 0; g < NG; g++) begin
            do_write(AW'(9'h080 + 4*g), 32'hFFFF_FFFF);
            do_write(AW'(9'h0C0 + 4*g), 32'hFFFF_FFFF);
        end
        for (int g = 0; g < NG; g++) do_write(AW'(9'h040 + 4*g), 32'hFFFF_FFFF);
        check("R7 all closed", GW'(irq_out), 32'h0);
        check("R8 all closed", GW'(exc_out), 32'h0);
        read_expect("R4 all cleared", 9'h00C, 32'h0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule